// File: doc/BRIEF.md
# Power-Up Reset Time-Out Sequencer

This block produces the internal reset for a small microcontroller core. A power-on pulse starts it. It can also be started by a brown-out event, by a wake-from-sleep request while the core runs, and by the active-low external reset pin. After power-on or brown-out it first counts a power-up delay in ticks of a slow, free-running time base. It then counts an oscillator start-up delay in oscillator clock cycles. Two configuration inputs decide which of the two delays are used: the oscillator mode and a power-up-delay disable bit.

Both delays are measured from the power-on pulse and not from the pin. A board can therefore hold the pin low past both delays and start the core a fixed few cycles after releasing it. This is useful for lock-step start of several devices. The internal reset comes from a flop in the oscillator clock domain, so it releases without glitches. Status outputs report whether the last full reset came from power-on or from brown-out, and whether the delay sequence has completed.

Top module: `rst_powerup_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1, `cause_por_o` is 1, `cause_bor_o` is 0 and `seq_done_o` is 0.
- R2: With `osc_rc_i`=0 (crystal mode) and `pwrt_dis_i`=0, the power-up delay runs first and ends on the PWRT_TICKS-th `tick_i` it samples, counting from the first clock edge after `por_i` falls. The start-up delay then runs for exactly OST_CYCLES clock cycles. `core_rst_o` falls on the edge that ends the start-up delay, which is the start-up delay's last cycle.
- R3: With `osc_rc_i`=1 (RC mode) and `pwrt_dis_i`=0, only the power-up delay runs, and `core_rst_o` falls on the edge that samples the PWRT_TICKS-th tick.
- R4: With `pwrt_dis_i`=1 in crystal mode, only the start-up delay runs. It begins on the first edge after release, so `core_rst_o` falls OST_CYCLES+1 edges after `por_i` falls.
- R5: With `pwrt_dis_i`=1 in RC mode there is no delay. `core_rst_o` falls SYNC_STAGES+1 edges after `por_i` falls, which is the time needed to qualify the pin.
- R6: While `bor_i` is high, reset is held, `seq_done_o` is 0, `cause_bor_o` is 1 and `cause_por_o` is 0. When `bor_i` falls, the full sequence restarts from its beginning, whatever phase it was in before.
- R7: A one-cycle `wake_i` pulse in crystal mode while the sequence is done raises `core_rst_o` on the next edge. It holds `core_rst_o` for exactly OST_CYCLES cycles and leaves the cause flags unchanged.
- R8: `wake_i` has no effect in RC mode, and no effect while a delay is still running.
- R9: The delays run from the power-on pulse. With `mclr_n_i` held low past both delays, `seq_done_o` is 1 while `core_rst_o` stays 1. `core_rst_o` then falls SYNC_STAGES+1 edges after the pin rises.
- R10: Pulling `mclr_n_i` low after the sequence is done raises `core_rst_o` SYNC_STAGES+1 edges later and does not restart the delays. After release, `core_rst_o` falls SYNC_STAGES+1 edges after the pin rises.
- R11: `core_rst_o` is 1 whenever `seq_done_o` is 0, and exactly one of `cause_por_o` and `cause_bor_o` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| bor_i | input | 1 | Brown-out event, active high, synchronous |
| wake_i | input | 1 | Wake-from-sleep request pulse |
| mclr_n_i | input | 1 | External reset pin, active low, asynchronous |
| osc_rc_i | input | 1 | Oscillator mode: 1 = RC, 0 = crystal type |
| pwrt_dis_i | input | 1 | 1 disables the power-up delay |
| tick_i | input | 1 | One-cycle strobe of the slow time base |
| core_rst_o | output | 1 | Internal reset to the core, active high |
| cause_por_o | output | 1 | Last full reset came from power-on |
| cause_bor_o | output | 1 | Last full reset came from brown-out |
| seq_done_o | output | 1 | Delay sequence finished |

## Verification
The assertions check several rules on every cycle: reset is held whenever the sequence is not done, the two cause flags stay one-hot, brown-out holds reset and sets its flag, and a pin held low long enough always forces reset. They also check that a wake request from the done state re-enters the start-up delay in crystal mode and is ignored in RC mode. Exact delay lengths need the bench's scenarios: the four mode and disable combinations, a brown-out that cuts into the start-up delay, a wake pulse sent during the power-up delay, and the late pin release. Each of these yields one measured release cycle that the scoreboard compares.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_ARM  = 2'd0,
        SEQ_PWRT = 2'd1,
        SEQ_OST  = 2'd2,
        SEQ_RUN  = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       rst;
        logic       cause_por;
        logic       cause_bor;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET_VAL = '{
        state:     SEQ_ARM,
        rst:       1'b1,
        cause_por: 1'b1,
        cause_bor: 1'b0
    };

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic pin_n_i,
    output logic pin_ok_o
);

    logic [STAGES-1:0] sync_d;
    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = pin_n_i;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], pin_n_i};
        end
    endgenerate

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign pin_ok_o = sync_q[STAGES-1];

endmodule

// File: rtl/rst_span_counter.sv
module rst_span_counter #(
    parameter int LIMIT = 1024
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        last_o = inc_i && !clr_i && (cnt_q == LAST_VAL);
        if (clr_i || last_o) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/rst_powerup_seq.sv
module rst_powerup_seq
    import rst_seq_pkg::*;
#(
    parameter int PWRT_TICKS  = 72,
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic bor_i,
    input  logic wake_i,
    input  logic mclr_n_i,
    input  logic osc_rc_i,
    input  logic pwrt_dis_i,
    input  logic tick_i,
    output logic core_rst_o,
    output logic cause_por_o,
    output logic cause_bor_o,
    output logic seq_done_o
);

    seq_regs_t seq_d;
    seq_regs_t seq_q;

    logic pin_ok;
    logic pwrt_clr;
    logic pwrt_last;
    logic ost_clr;
    logic ost_last;

    rst_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_pin_sync (
        .clk_i    (clk_i),
        .arst_i   (por_i),
        .pin_n_i  (mclr_n_i),
        .pin_ok_o (pin_ok)
    );

    rst_span_counter #(
        .LIMIT (PWRT_TICKS)
    ) u_pwrt_cnt (
        .clk_i  (clk_i),
        .arst_i (por_i),
        .clr_i  (pwrt_clr),
        .inc_i  (tick_i),
        .last_o (pwrt_last)
    );

    rst_span_counter #(
        .LIMIT (OST_CYCLES)
    ) u_ost_cnt (
        .clk_i  (clk_i),
        .arst_i (por_i),
        .clr_i  (ost_clr),
        .inc_i  (1'b1),
        .last_o (ost_last)
    );

    assign pwrt_clr = (seq_q.state != SEQ_PWRT);
    assign ost_clr  = (seq_q.state != SEQ_OST);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_ARM: begin
                if (!pwrt_dis_i) begin
                    seq_d.state = SEQ_PWRT;
                end else if (!osc_rc_i) begin
                    seq_d.state = SEQ_OST;
                end else begin
                    seq_d.state = SEQ_RUN;
                end
            end
            SEQ_PWRT: begin
                if (pwrt_last) begin
                    seq_d.state = osc_rc_i ? SEQ_RUN : SEQ_OST;
                end
            end
            SEQ_OST: begin
                if (ost_last) begin
                    seq_d.state = SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                if (wake_i && !osc_rc_i) begin
                    seq_d.state = SEQ_OST;
                end
            end
            default: seq_d.state = SEQ_ARM;
        endcase
        if (bor_i) begin
            seq_d.state     = SEQ_ARM;
            seq_d.cause_bor = 1'b1;
            seq_d.cause_por = 1'b0;
        end
        seq_d.rst = (seq_d.state != SEQ_RUN) || !pin_ok;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            seq_q <= SEQ_RESET_VAL;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign core_rst_o  = seq_q.rst;
    assign cause_por_o = seq_q.cause_por;
    assign cause_bor_o = seq_q.cause_bor;
    assign seq_done_o  = (seq_q.state == SEQ_RUN);

endmodule

// File: rtl/rst_powerup_seq_chk.sv
module rst_powerup_seq_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk_i,
    input logic por_i,
    input logic bor_i,
    input logic wake_i,
    input logic mclr_n_i,
    input logic osc_rc_i,
    input logic core_rst_o,
    input logic cause_por_o,
    input logic cause_bor_o,
    input logic seq_done_o
);

    logic [7:0] low_cnt_q;

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            low_cnt_q <= '0;
        end else if (mclr_n_i) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != 8'hFF) begin
            low_cnt_q <= low_cnt_q + 8'd1;
        end
    end

    AST_PIN_LOW_FORCES_RST: assert property (@(posedge clk_i) disable iff (por_i)
        (int'(low_cnt_q) > SYNC_STAGES) |-> core_rst_o); // R10

    AST_NOT_DONE_HOLDS_RST: assert property (@(posedge clk_i) disable iff (por_i)
        !seq_done_o |-> core_rst_o); // R11

    AST_CAUSE_ONEHOT: assert property (@(posedge clk_i) disable iff (por_i)
        $onehot({cause_por_o, cause_bor_o})); // R11

    AST_BOR_HOLDS_RST: assert property (@(posedge clk_i) disable iff (por_i)
        bor_i |=> (core_rst_o && !seq_done_o && cause_bor_o)); // R6

    AST_XTAL_WAKE_REARMS: assert property (@(posedge clk_i) disable iff (por_i)
        (seq_done_o && wake_i && !osc_rc_i && !bor_i) |=> (!seq_done_o && core_rst_o)); // R7

    AST_RC_WAKE_IGNORED: assert property (@(posedge clk_i) disable iff (por_i)
        (seq_done_o && wake_i && osc_rc_i && !bor_i) |=> seq_done_o); // R8

endmodule

bind rst_powerup_seq rst_powerup_seq_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/rst_powerup_seq_bench.sv
module rst_powerup_seq_bench;

    localparam int PT   = 72;
    localparam int OC   = 1024;
    localparam int SS   = 2;
    localparam int TDIV = 4;

    logic clk_i = 1'b0;
    logic por_i = 1'b1;
    logic bor_i = 1'b0;
    logic wake_i = 1'b0;
    logic mclr_n_i = 1'b1;
    logic osc_rc_i = 1'b0;
    logic pwrt_dis_i = 1'b0;
    logic tick_i = 1'b0;
    logic core_rst_o, cause_por_o, cause_bor_o, seq_done_o;

    int checks = 0;
    int errors = 0;
    int ecnt = 0;
    int mark = 0;
    int cyc = 0;
    bit prev_rst = 1'b1;
    int exp_q[$];
    string req_q[$];

    always #10 clk_i = ~clk_i;

    rst_powerup_seq #(.PWRT_TICKS(PT), .OST_CYCLES(OC), .SYNC_STAGES(SS)) u_rst_powerup_seq (
        .clk_i(clk_i), .por_i(por_i), .bor_i(bor_i), .wake_i(wake_i),
        .mclr_n_i(mclr_n_i), .osc_rc_i(osc_rc_i), .pwrt_dis_i(pwrt_dis_i),
        .tick_i(tick_i), .core_rst_o(core_rst_o), .cause_por_o(cause_por_o),
        .cause_bor_o(cause_bor_o), .seq_done_o(seq_done_o)
    );

    always @(posedge clk_i or posedge por_i) begin
        if (por_i) ecnt <= 0;
        else       ecnt <= ecnt + 1;
    end

    always @(negedge clk_i) tick_i = (((ecnt + 1) % TDIV) == 0);

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // monitor: measures the release edge relative to the mark and compares
    always @(negedge clk_i) begin
        if (prev_rst && !core_rst_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected release", ecnt - mark, -1);
            end else begin
                int e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk((ecnt - mark) == e, r, ecnt - mark, e);
            end
        end
        prev_rst = core_rst_o;
    end

    always @(posedge clk_i) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic expect_rel(input int d, input string r);
        exp_q.push_back(d);
        req_q.push_back(r);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk_i);
    endtask

    task automatic power_on(input bit rc, input bit dis);
        @(negedge clk_i);
        por_i = 1'b1;
        osc_rc_i = rc;
        pwrt_dis_i = dis;
        repeat (3) @(negedge clk_i);
        por_i = 1'b0;
        mark = 0;
    endtask

    initial begin
        // R1: state during the power-on pulse
        osc_rc_i = 1'b0;
        pwrt_dis_i = 1'b0;
        repeat (3) @(negedge clk_i);
        chk(core_rst_o == 1'b1, "R1 rst", core_rst_o, 1);
        chk(cause_por_o == 1'b1 && cause_bor_o == 1'b0, "R1 cause", {cause_por_o, cause_bor_o}, 2);
        chk(seq_done_o == 1'b0, "R1 done", seq_done_o, 0);
        chk(cause_por_o != cause_bor_o, "R11 onehot", {cause_por_o, cause_bor_o}, 2);
        por_i = 1'b0;
        mark = 0;
        expect_rel(TDIV * PT + OC, "R2 xtal+pwrt");
        // R8: a wake pulse during the power-up delay changes nothing
        while (ecnt != 100) @(negedge clk_i);
        wake_i = 1'b1;
        @(negedge clk_i);
        wake_i = 1'b0;
        drain();
        chk(seq_done_o == 1'b1, "R2 done", seq_done_o, 1);

        // R7: wake in crystal mode
        repeat (5) @(negedge clk_i);
        wake_i = 1'b1;
        mark = ecnt;
        expect_rel(OC + 1, "R7 wake ost");
        @(negedge clk_i);
        wake_i = 1'b0;
        chk(core_rst_o == 1'b1, "R7 rst rises", core_rst_o, 1);
        drain();
        chk(cause_por_o == 1'b1 && cause_bor_o == 1'b0, "R7 cause kept", {cause_por_o, cause_bor_o}, 2);

        // R8: wake in RC mode is ignored
        osc_rc_i = 1'b1;
        @(negedge clk_i);
        wake_i = 1'b1;
        @(negedge clk_i);
        wake_i = 1'b0;
        repeat (10) @(negedge clk_i);
        chk(core_rst_o == 1'b0 && seq_done_o == 1'b1, "R8 rc wake", core_rst_o, 0);

        power_on(1'b1, 1'b0);
        expect_rel(TDIV * PT, "R3 rc+pwrt");
        drain();

        power_on(1'b0, 1'b1);
        expect_rel(OC + 1, "R4 xtal only");
        drain();

        power_on(1'b1, 1'b1);
        expect_rel(SS + 1, "R5 no delay");
        drain();

        // R6: brown-out during the start-up delay
        power_on(1'b0, 1'b0);
        while (ecnt != 400) @(negedge clk_i);
        bor_i = 1'b1;
        repeat (2) @(negedge clk_i);
        chk(core_rst_o == 1'b1 && seq_done_o == 1'b0, "R6 hold", core_rst_o, 1);
        chk(cause_bor_o == 1'b1 && cause_por_o == 1'b0, "R6 cause", {cause_por_o, cause_bor_o}, 1);
        while ((ecnt % TDIV) != 0) @(negedge clk_i);
        bor_i = 1'b0;
        mark = ecnt;
        expect_rel(TDIV * PT + OC, "R6 restart");
        drain();

        // R9: pin held low past both delays
        mclr_n_i = 1'b0;
        power_on(1'b0, 1'b0);
        while (ecnt != TDIV * PT + OC + 10) @(negedge clk_i);
        chk(seq_done_o == 1'b1, "R9 done", seq_done_o, 1);
        chk(core_rst_o == 1'b1, "R9 held", core_rst_o, 1);
        mclr_n_i = 1'b1;
        mark = ecnt;
        expect_rel(SS + 1, "R9 late pin");
        drain();

        // R10: pin pulled low while running
        repeat (4) @(negedge clk_i);
        mclr_n_i = 1'b0;
        repeat (SS) @(negedge clk_i);
        chk(core_rst_o == 1'b0, "R10 not yet", core_rst_o, 0);
        @(negedge clk_i);
        chk(core_rst_o == 1'b1, "R10 asserted", core_rst_o, 1);
        repeat (20) @(negedge clk_i);
        chk(seq_done_o == 1'b1, "R10 no restart", seq_done_o, 1);
        mclr_n_i = 1'b1;
        mark = ecnt;
        expect_rel(SS + 1, "R10 release");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule